// File: doc/BRIEF.md
# Half-Duplex Line Direction Arbiter

This block sits between two open-drain segments of one half-duplex data line: a host segment and a card segment. Each segment is idle high. The block samples both segments and relays a low level from one segment to the other. The first segment on which a falling edge is seen becomes the master for the current transfer. The other segment becomes the slave, and the block pulls the slave segment low once a programmable delay has passed. When the master releases the line, the block drives the slave segment high for a short, timed pulse so that the rising edge is fast. It then returns to idle.

For each side the block has one pull-low enable and one active pull-up enable. Outside drivers turn these into pad behaviour. Resistors, current limiting and level shifting are outside the block. Both line inputs go through two-flop synchronisers before edge detection. The state machine has four states. IDLE is the state with no transfer. DELAY counts the propagation delay. COPY drives the slave segment low. PULSE drives the slave segment high.

The state machine has the following named transitions:
- **start** goes from IDLE to DELAY when a falling edge is seen and latches the direction.
- **expire** goes from DELAY to COPY when the delay count is reached.
- **early-release** goes from DELAY to PULSE.
- **release** goes from COPY to PULSE when the master is seen high.
- **finish** goes from PULSE to IDLE when the pulse count is reached.

Top module: `io_dir_arbiter`

## Requirements
- R1: While reset is asserted, and in IDLE, all four enables (both pull-low and both pull-up) are 0.
- R2: A low on the master segment enables pull-low on the slave side from rising edge DELAY_CYC+3 onward. Edge 1 is the first rising edge that samples the low. The enable holds until the release is seen.
- R3: The first side to show a falling edge becomes master. If both sides fall in the same cycle, the host side is master.
- R4: While a transfer is in progress, falling edges on the slave segment are ignored. The direction and the slave enables are unaffected by them.
- R5: The master returns high, sampled at edge 1. From edge 3, the slave pull-up enable is 1 for exactly PULSE_CYC cycles. The slave pull-low enable is 0 from that same edge.
- R6: After the pull-up pulse, the block is in IDLE with all enables 0, and it accepts a new falling edge on either side.
- R7: If the master returns high during the delay, the slave is never pulled low, and the pull-up pulse of PULSE_CYC cycles is still given.
- R8: No side has pull-low and pull-up enabled in the same cycle, and at most one enable of the four is 1 at any time. The master side is never driven.
- R9: When the card side is master, the roles are mirrored: the block drives the host side's enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_line_i | input | 1 | Sampled level of the host segment |
| card_line_i | input | 1 | Sampled level of the card segment |
| host_pull_low_o | output | 1 | Pull the host segment low |
| card_pull_low_o | output | 1 | Pull the card segment low |
| host_pull_up_o | output | 1 | Actively drive the host segment high |
| card_pull_up_o | output | 1 | Actively drive the card segment high |

## Verification
The bench's main target is the block's reaction to its own drive. While the slave segment is pulled low, it must not read that low as a new edge. A design with a broken lockout would flip direction or latch both segments low. The bench also makes both sides fall in the same cycle; a design that resolves this the wrong way would give the card side the transfer. It releases the master during the delay; a wrong design would drop the pull-up pulse or leave a stray pull-low. It also counts the exact edges at which the drive starts and the pulse ends; an off-by-one counter would shift the edge where the slave goes low or change the pulse length.

// File: rtl/iodir_pkg.sv
package iodir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_COPY,
        ST_PULSE
    } arb_state_t;

    localparam int SIDE_HOST = 0;
    localparam int SIDE_CARD = 1;
    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/iodir_sync.sv
module iodir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/iodir_fsm.sv
module iodir_fsm
    import iodir_pkg::*;
#(
    parameter int DELAY_CYC = 6,
    parameter int PULSE_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SIDES-1:0] level_i,
    input  logic [NUM_SIDES-1:0] fall_i,
    output logic [NUM_SIDES-1:0] pull_low_o,
    output logic [NUM_SIDES-1:0] pull_up_o
);
    localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CW-1:0] DELAY_LAST = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);

    arb_state_t    state_q, state_d;
    logic          dir_q, dir_d;      // 0: host is master, 1: card is master
    logic [CW-1:0] cnt_q, cnt_d;
    logic          master_hi;

    assign master_hi = level_i[dir_q];

    // next-state and state register
    always_comb begin
        state_d = state_q;
        dir_d   = dir_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (fall_i[SIDE_HOST]) begin
                    dir_d   = 1'b0;
                    state_d = ST_DELAY;
                end else if (fall_i[SIDE_CARD]) begin
                    dir_d   = 1'b1;
                    state_d = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (master_hi) begin
                    state_d = ST_PULSE;
                    cnt_d   = '0;
                end else if (cnt_q == DELAY_LAST) begin
                    state_d = ST_COPY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_COPY: begin
                if (master_hi) begin
                    state_d = ST_PULSE;
                    cnt_d   = '0;
                end
            end
            ST_PULSE: begin
                if (cnt_q == PULSE_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
            cnt_q   <= cnt_d;
        end
    end

    // output decode: only the slave side (index ~dir_q) is ever driven
    always_comb begin
        pull_low_o = '0;
        pull_up_o  = '0;
        unique case (state_q)
            ST_IDLE, ST_DELAY: ;
            ST_COPY:  pull_low_o[~dir_q] = 1'b1;
            ST_PULSE: pull_up_o[~dir_q]  = 1'b1;
            default: ;
        endcase
    end

    // R8
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_low_o & pull_up_o) == '0);

    // R8
    single_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pull_low_o, pull_up_o}) <= 1);

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(dir_q));

    // R3
    host_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fall_i[SIDE_HOST]) |=> (dir_q == 1'b0 && state_q == ST_DELAY));

    // R5
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COPY && master_hi) |=> (pull_up_o[~dir_q] && pull_low_o == '0));

    // R6
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && cnt_q == PULSE_LAST) |=> (pull_up_o == '0 && pull_low_o == '0));
endmodule

// File: rtl/io_dir_arbiter.sv
module io_dir_arbiter
    import iodir_pkg::*;
#(
    parameter int DELAY_CYC   = 6,
    parameter int PULSE_CYC   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_line_i,
    input  logic card_line_i,
    output logic host_pull_low_o,
    output logic card_pull_low_o,
    output logic host_pull_up_o,
    output logic card_pull_up_o
);
    logic [NUM_SIDES-1:0] raw_line;
    logic [NUM_SIDES-1:0] level;
    logic [NUM_SIDES-1:0] fall;
    logic [NUM_SIDES-1:0] pull_low;
    logic [NUM_SIDES-1:0] pull_up;

    assign raw_line[SIDE_HOST] = host_line_i;
    assign raw_line[SIDE_CARD] = card_line_i;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        iodir_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_line[s]),
            .level_o (level[s]),
            .fall_o  (fall[s])
        );
    end

    iodir_fsm #(
        .DELAY_CYC (DELAY_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (level),
        .fall_i     (fall),
        .pull_low_o (pull_low),
        .pull_up_o  (pull_up)
    );

    assign host_pull_low_o = pull_low[SIDE_HOST];
    assign card_pull_low_o = pull_low[SIDE_CARD];
    assign host_pull_up_o  = pull_up[SIDE_HOST];
    assign card_pull_up_o  = pull_up[SIDE_CARD];
endmodule

// File: tb/io_dir_arbiter_test.sv
`timescale 1ns/1ps
module io_dir_arbiter_test;
    localparam int D = 6;
    localparam int P = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_h = 1'b1;
    logic ext_c = 1'b1;
    logic host_pull_low, card_pull_low, host_pull_up, card_pull_up;
    wire  host_line = ext_h & ~host_pull_low;
    wire  card_line = ext_c & ~card_pull_low;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    io_dir_arbiter #(.DELAY_CYC(D), .PULSE_CYC(P), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_line_i(host_line), .card_line_i(card_line),
        .host_pull_low_o(host_pull_low), .card_pull_low_o(card_pull_low),
        .host_pull_up_o(host_pull_up), .card_pull_up_o(card_pull_up)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: sample history queues and a phase/timer pair
    bit hq[$];
    bit cq[$];
    int phase = 0;   // 0 quiet, 1 waiting, 2 relaying low, 3 pull-up pulse
    int who   = 0;   // 0 host leads, 1 card leads
    int tmr   = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hq = '{1'b1, 1'b1, 1'b1};
            cq = '{1'b1, 1'b1, 1'b1};
            phase = 0; who = 0; tmr = 0;
        end else begin
            bit h_fell, c_fell, lead_hi;
            h_fell  = hq[0] && !hq[1];
            c_fell  = cq[0] && !cq[1];
            lead_hi = (who == 0) ? hq[1] : cq[1];
            case (phase)
                0: if (h_fell) begin who = 0; phase = 1; tmr = 0; end
                   else if (c_fell) begin who = 1; phase = 1; tmr = 0; end
                1: if (lead_hi) begin phase = 3; tmr = 0; end
                   else if (tmr == D - 1) phase = 2;
                   else tmr++;
                2: if (lead_hi) begin phase = 3; tmr = 0; end
                3: if (tmr == P - 1) phase = 0;
                   else tmr++;
                default: phase = 0;
            endcase
            void'(hq.pop_front()); hq.push_back(host_line);
            void'(cq.pop_front()); cq.push_back(card_line);
        end
    end

    // cycle compare against the reference, away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            chk("R2/R9 host_pull_low", host_pull_low, (phase == 2 && who == 1));
            chk("R2 card_pull_low",    card_pull_low, (phase == 2 && who == 0));
            chk("R5/R9 host_pull_up",  host_pull_up,  (phase == 3 && who == 1));
            chk("R5 card_pull_up",     card_pull_up,  (phase == 3 && who == 0));
            chk("R8 single drive", $countones({host_pull_low, card_pull_low, host_pull_up, card_pull_up}) <= 1, 1);
        end
    end

    int n_hl, n_cl, n_hu, n_cu;
    task automatic run_count(input int n);
        n_hl = 0; n_cl = 0; n_hu = 0; n_cu = 0;
        repeat (n) begin
            @(negedge clk);
            n_hl += host_pull_low; n_cl += card_pull_low;
            n_hu += host_pull_up;  n_cu += card_pull_up;
        end
    endtask

    task automatic check_idle(input string req);
        chk({req, " idle host_pull_low"}, host_pull_low, 0);
        chk({req, " idle card_pull_low"}, card_pull_low, 0);
        chk({req, " idle host_pull_up"},  host_pull_up, 0);
        chk({req, " idle card_pull_up"},  card_pull_up, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;
        model_on = 1'b1;
        run_count(5);
        check_idle("R1");

        // host leads: R2, R5, R6
        ext_h = 1'b0;
        run_count(30);
        chk("R2 card low cycles", n_cl, 28 - D);
        chk("R8 host never driven", n_hl + n_hu, 0);
        ext_h = 1'b1;
        run_count(20);
        chk("R5 card low after release", n_cl, 2);
        chk("R5 card pulse length", n_cu, P);
        check_idle("R6");

        // card leads: R9
        ext_c = 1'b0;
        run_count(30);
        chk("R9 host low cycles", n_hl, 28 - D);
        chk("R9 card never driven", n_cl + n_cu, 0);
        ext_c = 1'b1;
        run_count(20);
        chk("R9 host pulse length", n_hu, P);
        check_idle("R6 after card");

        // simultaneous falls: R3
        ext_h = 1'b0; ext_c = 1'b0;
        run_count(30);
        chk("R3 tie card low cycles", n_cl, 28 - D);
        chk("R3 tie host not driven", n_hl, 0);
        ext_h = 1'b1; ext_c = 1'b1;
        run_count(20);
        chk("R3 tie card pulse", n_cu, P);

        // slave-side edge during relay: R4
        ext_h = 1'b0;
        run_count(15);
        chk("R4 pre low count", n_cl, 15 - (D + 2));
        ext_c = 1'b0;
        run_count(5);
        chk("R4 card still driven", n_cl, 5);
        chk("R4 host untouched", n_hl + n_hu, 0);
        ext_c = 1'b1;
        run_count(10);
        chk("R4 relay continues", n_cl, 10);
        ext_h = 1'b1;
        run_count(20);
        chk("R4 pulse on card", n_cu, P);
        chk("R4 no host drive", n_hl + n_hu, 0);

        // release inside the delay: R7
        ext_h = 1'b0;
        @(negedge clk);
        ext_h = 1'b1;
        run_count(20);
        chk("R7 no card low", n_cl, 0);
        chk("R7 pulse still given", n_cu, P);
        check_idle("R7");

        // random traffic compared against the reference every cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) ext_h = ~ext_h;
            if ($urandom_range(0, 15) == 0) ext_c = ~ext_c;
        end
        ext_h = 1'b1; ext_c = 1'b1;
        run_count(40);
        check_idle("R6 final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule